// File: doc/BRIEF.md
# Serial Engine Run-State Controller

This block holds the operating mode of a serial (I2C) engine in a small register and steps that engine between three modes: held in reset, running, and paused. Software asks for a mode by writing a two-bit code over a plain write strobe. It then reads back a state word that shows the current mode, a settled flag and an engine-ready flag. Every accepted change drops the settled flag for a fixed delay. The delay is a number of system-clock cycles followed by a number of core-clock enable ticks. The block therefore runs on one clock, and the slower engine clock appears only as a tick input.

The run and pause enables to the engine are asserted only once the mode has settled. Leaving the reset mode produces a one-cycle flush pulse. That pulse empties the engine's FIFOs and zeroes its transfer counters. A one-shot software reset forces the reset mode and issues clear pulses for pending service and error conditions. Writing the reset code while an error is pending also clears that error.

Top module: `core_state_ctrl`

## Requirements
- R1: After the synchronous reset input, the mode is RESET (code 0), the settled flag is 1, the ready flag is 0, both enables are 0 and no pulse output is high.
- R2: The state word carries the mode code in bits 1:0 (0 = RESET, 1 = RUN, 3 = PAUSE), the settled flag in bit 2, the ready flag in bit 4, and zeros in every other bit. An accepted write of code 0, 1 or 3 shows in bits 1:0 on the next cycle.
- R3: The settled flag goes low on the cycle after an accepted change or software reset. It returns high after BUS_SETTLE clock cycles followed by CORE_SETTLE cycles with core_tick high. Ticks during the first phase are not counted. With the defaults (3 and 3) and core_tick held high, the flag stays low for exactly 6 cycles. With core_tick held low, it never returns.
- R4: A mode write made while the settled flag is low is ignored. The mode stays as it was.
- R5: A write of code 2 is ignored. The mode and the settled flag stay unchanged, and no pulse is produced.
- R6: run_en is high exactly when the mode is RUN and settled. pause_en is high exactly when the mode is PAUSE and settled.
- R7: Bit 4 is high when the settled flag is high and eng_idle was high at the previous clock edge. It reads 0 on the cycle after a software reset.
- R8: A sw_rst pulse takes priority over a write made in the same cycle. On the next cycle the mode is RESET, the settled flag is low and settling restarts, and svc_clr and err_clr are each high for that one cycle.
- R9: An accepted write of RUN or PAUSE while the mode is RESET makes fifo_flush high for the one following cycle. No other event raises fifo_flush.
- R10: An accepted write of RESET while err_pending is high makes err_clr high for the one following cycle. Without err_pending, such a write raises no err_clr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Mode write strobe |
| wr_data | input | 2 | Requested mode code |
| sw_rst | input | 1 | One-shot software reset strobe |
| core_tick | input | 1 | Clock-enable tick of the engine clock domain |
| eng_idle | input | 1 | Engine master is idle and may accept a message |
| err_pending | input | 1 | A bus error is latched in the engine |
| state_word | output | WORD_W | Readable state word (mode, settled, ready) |
| run_en | output | 1 | Engine run enable |
| pause_en | output | 1 | Engine pause enable |
| fifo_flush | output | 1 | One-cycle FIFO flush and counter clear |
| svc_clr | output | 1 | One-cycle clear of pending service conditions |
| err_clr | output | 1 | One-cycle clear of the latched error |

## Verification
The mode field, the pulse outputs and the ready flag change on the first clock edge after the stimulus that causes them. The settled flag returns only after its full two-phase count. The enables follow the mode and the settled flag without an added register. The bench drives inputs at the falling edge and lets one rising edge pass. It compares every output at the next falling edge against a model stepped once per edge, so each result is checked on the exact cycle it is due. The settling length is also measured directly by counting low cycles after a write, and a run with core_tick held low confirms that bus cycles alone never end the settling.

// File: rtl/csc_pkg.sv
package csc_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE = 2'b00,
        MODE_RUN  = 2'b01,
        MODE_HOLD = 2'b11
    } core_mode_e;

    localparam int MODE_W    = 2;
    localparam int VALID_POS = 2;
    localparam int READY_POS = 4;

    typedef struct packed {
        logic flush;
        logic svc_clr;
        logic err_clr;
    } clr_pulses_t;

    function automatic logic code_legal(input logic [MODE_W-1:0] code);
        return code != 2'b10;
    endfunction

endpackage

// File: rtl/csc_settle_timer.sv
module csc_settle_timer #(
    parameter int BUS_SETTLE  = 3,
    parameter int CORE_SETTLE = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic tick,
    output logic settled
);
    localparam int BW = $clog2(BUS_SETTLE + 1);
    localparam int TW = $clog2(CORE_SETTLE + 1);

    logic [BW-1:0] bus_left;
    logic [TW-1:0] tick_left;

    always_ff @(posedge clk) begin
        if (rst) begin
            settled   <= 1'b1;
            bus_left  <= '0;
            tick_left <= '0;
        end else if (start) begin
            settled   <= 1'b0;
            bus_left  <= BW'(BUS_SETTLE);
            tick_left <= TW'(CORE_SETTLE);
        end else if (!settled) begin
            if (bus_left != '0) begin
                bus_left <= bus_left - 1'b1;
            end else if (tick) begin
                if (tick_left == TW'(1)) settled <= 1'b1;
                tick_left <= tick_left - 1'b1;
            end
        end
    end

    // R3: a start always drops the settled flag on the next cycle
    p_drop_on_start_r3: assert property (@(posedge clk) disable iff (rst)
        start |=> !settled);
    // R3: settling never completes during the bus-cycle phase
    p_no_early_settle_r3: assert property (@(posedge clk) disable iff (rst)
        (!settled && bus_left != '0 && !start) |=> !settled);
endmodule

// File: rtl/csc_mode_reg.sv
module csc_mode_reg
    import csc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [MODE_W-1:0] wr_code,
    input  logic              sw_rst,
    input  logic              settled,
    input  logic              err_pending,
    output core_mode_e        mode,
    output logic              start,
    output clr_pulses_t       pulses
);
    logic accept;

    assign accept = wr_en && settled && code_legal(wr_code) && !sw_rst;
    assign start  = sw_rst || accept;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode   <= MODE_IDLE;
            pulses <= '0;
        end else begin
            pulses <= '0;
            if (sw_rst) begin
                mode           <= MODE_IDLE;
                pulses.svc_clr <= 1'b1;
                pulses.err_clr <= 1'b1;
            end else if (accept) begin
                mode <= core_mode_e'(wr_code);
                if (mode == MODE_IDLE && wr_code != MODE_IDLE)
                    pulses.flush <= 1'b1;
                if (wr_code == MODE_IDLE && err_pending)
                    pulses.err_clr <= 1'b1;
            end
        end
    end

    // R9: a flush pulse only follows a departure from the reset mode
    p_flush_leaves_reset_r9: assert property (@(posedge clk) disable iff (rst)
        pulses.flush |-> ($past(mode) == MODE_IDLE && mode != MODE_IDLE));
    // R5: code 2 never alters the mode
    p_code2_ignored_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_code == 2'b10 && !sw_rst) |=> $stable(mode));
    // R4: writes while unsettled are dropped
    p_busy_write_ignored_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !settled && !sw_rst) |=> $stable(mode));
    // R8: software reset forces the reset mode and both clears
    p_swrst_effect_r8: assert property (@(posedge clk) disable iff (rst)
        sw_rst |=> (mode == MODE_IDLE && pulses.svc_clr && pulses.err_clr));
endmodule

// File: rtl/csc_ready_flag.sv
module csc_ready_flag (
    input  logic clk,
    input  logic rst,
    input  logic eng_idle,
    input  logic sw_rst,
    output logic idle_q
);
    always_ff @(posedge clk) begin
        if (rst) idle_q <= 1'b0;
        else     idle_q <= eng_idle && !sw_rst;
    end

    // R7: the ready source is cleared after a software reset
    p_ready_cleared_r7: assert property (@(posedge clk) disable iff (rst)
        sw_rst |=> !idle_q);
endmodule

// File: rtl/core_state_ctrl.sv
module core_state_ctrl
    import csc_pkg::*;
#(
    parameter int WORD_W      = 32,
    parameter int BUS_SETTLE  = 3,
    parameter int CORE_SETTLE = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_data,
    input  logic              sw_rst,
    input  logic              core_tick,
    input  logic              eng_idle,
    input  logic              err_pending,
    output logic [WORD_W-1:0] state_word,
    output logic              run_en,
    output logic              pause_en,
    output logic              fifo_flush,
    output logic              svc_clr,
    output logic              err_clr
);
    core_mode_e  mode;
    logic        start;
    logic        settled;
    logic        idle_q;
    clr_pulses_t pulses;

    csc_mode_reg u_mode (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_code     (wr_data),
        .sw_rst      (sw_rst),
        .settled     (settled),
        .err_pending (err_pending),
        .mode        (mode),
        .start       (start),
        .pulses      (pulses)
    );

    csc_settle_timer #(
        .BUS_SETTLE  (BUS_SETTLE),
        .CORE_SETTLE (CORE_SETTLE)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .tick    (core_tick),
        .settled (settled)
    );

    csc_ready_flag u_ready (
        .clk      (clk),
        .rst      (rst),
        .eng_idle (eng_idle),
        .sw_rst   (sw_rst),
        .idle_q   (idle_q)
    );

    always_comb begin
        state_word                = '0;
        state_word[MODE_W-1:0]    = mode;
        state_word[VALID_POS]     = settled;
        state_word[READY_POS]     = settled && idle_q;
    end

    assign run_en     = settled && (mode == MODE_RUN);
    assign pause_en   = settled && (mode == MODE_HOLD);
    assign fifo_flush = pulses.flush;
    assign svc_clr    = pulses.svc_clr;
    assign err_clr    = pulses.err_clr;

    // R6: the engine is never both running and paused
    p_enables_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
        !(run_en && pause_en));
    // R6: no enable while settling
    p_no_enable_unsettled_r6: assert property (@(posedge clk) disable iff (rst)
        !state_word[VALID_POS] |-> !(run_en || pause_en));
endmodule

// File: tb/sim_core_state_ctrl.sv
module sim_core_state_ctrl;
    localparam int BS = 3;
    localparam int CS = 3;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en, sw_rst, core_tick, eng_idle, err_pending;
    logic [1:0]  wr_data;
    logic [31:0] state_word;
    logic        run_en, pause_en, fifo_flush, svc_clr, err_clr;

    int n_cmp = 0;
    int n_bad = 0;

    // model state (value after the most recent edge)
    logic [1:0] m_mode;
    logic       m_valid, m_rdy, m_flush, m_svc, m_errc;
    int         m_bus, m_tk;

    core_state_ctrl u0 (
        .clk (clk), .rst (rst), .wr_en (wr_en), .wr_data (wr_data),
        .sw_rst (sw_rst), .core_tick (core_tick), .eng_idle (eng_idle),
        .err_pending (err_pending), .state_word (state_word),
        .run_en (run_en), .pause_en (pause_en), .fifo_flush (fifo_flush),
        .svc_clr (svc_clr), .err_clr (err_clr)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_word();
        logic [31:0] w = '0;
        w[1:0] = m_mode;
        w[2]   = m_valid;
        w[4]   = m_valid && m_rdy;
        return w;
    endfunction

    task automatic check_all();
        chk("R2 state word", state_word, exp_word());
        chk("R3 settled flag", 32'(state_word[2]), 32'(m_valid));
        chk("R7 ready flag", 32'(state_word[4]), 32'(m_valid && m_rdy));
        chk("R6 run_en", 32'(run_en), 32'(m_valid && m_mode == 2'd1));
        chk("R6 pause_en", 32'(pause_en), 32'(m_valid && m_mode == 2'd3));
        chk("R9 fifo_flush", 32'(fifo_flush), 32'(m_flush));
        chk("R8 svc_clr", 32'(svc_clr), 32'(m_svc));
        chk("R10 err_clr", 32'(err_clr), 32'(m_errc));
    endtask

    task automatic model_edge();
        m_flush = 1'b0; m_svc = 1'b0; m_errc = 1'b0;
        if (sw_rst) begin
            m_svc = 1'b1; m_errc = 1'b1;
            m_mode = 2'd0; m_valid = 1'b0; m_bus = BS; m_tk = CS;
        end else if (wr_en && m_valid && wr_data != 2'd2) begin
            if (m_mode == 2'd0 && wr_data != 2'd0) m_flush = 1'b1;
            if (wr_data == 2'd0 && err_pending) m_errc = 1'b1;
            m_mode = wr_data; m_valid = 1'b0; m_bus = BS; m_tk = CS;
        end else if (!m_valid) begin
            if (m_bus != 0) m_bus--;
            else if (core_tick) begin
                if (m_tk == 1) m_valid = 1'b1;
                m_tk--;
            end
        end
        m_rdy = eng_idle && !sw_rst;
    endtask

    // called at a falling edge: apply inputs, pass one rising edge, check
    task automatic step(input logic w, input logic [1:0] d, input logic s,
                        input logic t, input logic idl, input logic e);
        wr_en = w; wr_data = d; sw_rst = s; core_tick = t;
        eng_idle = idl; err_pending = e;
        model_edge();
        @(posedge clk);
        @(negedge clk);
        check_all();
    endtask

    task automatic idle_step(input logic t);
        step(1'b0, 2'd0, 1'b0, t, 1'b1, 1'b0);
    endtask

    task automatic settle();
        for (int i = 0; i < 20 && !state_word[2]; i++) idle_step(1'b1);
    endtask

    initial begin
        int lows;
        logic [1:0] held;
        void'($urandom(32'd4711));
        rst = 1'b1; wr_en = 0; wr_data = 0; sw_rst = 0; core_tick = 0;
        eng_idle = 0; err_pending = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_mode = 2'd0; m_valid = 1'b1; m_rdy = 1'b0; m_bus = 0; m_tk = 0;
        m_flush = 0; m_svc = 0; m_errc = 0;
        // R1 reset state
        chk("R1 reset word", state_word, 32'h4);
        chk("R1 reset enables", 32'({run_en, pause_en}), 32'h0);
        chk("R1 reset pulses", 32'({fifo_flush, svc_clr, err_clr}), 32'h0);

        // R3 settle length with tick held high; R9 flush when leaving RESET
        step(1'b1, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0);
        chk("R9 flush after leaving reset", 32'(fifo_flush), 32'h1);
        lows = 0;
        while (!state_word[2] && lows < 50) begin
            lows++;
            idle_step(1'b1);
        end
        chk("R3 settle cycles", 32'(lows), 32'(BS + CS));
        chk("R2 mode RUN", 32'(state_word[1:0]), 32'd1);

        // R5 code 2 ignored
        step(1'b1, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0);
        chk("R5 code 2 mode", 32'(state_word[1:0]), 32'd1);
        chk("R5 code 2 settled", 32'(state_word[2]), 32'd1);

        // R4 write while settling ignored
        step(1'b1, 2'd3, 1'b0, 1'b1, 1'b1, 1'b0);
        step(1'b1, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0);
        settle();
        chk("R4 busy write ignored", 32'(state_word[1:0]), 32'd3);

        // R8 software reset beats a same-cycle write
        step(1'b1, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0);
        chk("R8 swrst mode", 32'(state_word[1:0]), 32'd0);
        chk("R8 swrst clears", 32'({svc_clr, err_clr}), 32'h3);
        chk("R7 ready after swrst", 32'(state_word[4]), 32'd0);
        settle();

        // R10 RESET write with pending error
        step(1'b1, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1);
        chk("R10 err_clr pulse", 32'(err_clr), 32'd1);
        settle();

        // R3 ticks low: bus cycles alone never settle
        step(1'b1, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0);
        for (int i = 0; i < 10; i++) idle_step(1'b0);
        chk("R3 no settle without ticks", 32'(state_word[2]), 32'd0);
        settle();

        // constrained random phase
        for (int i = 0; i < 4000; i++) begin
            held = 2'($urandom_range(0, 3));
            step(($urandom_range(0, 3) == 0), held, ($urandom_range(0, 60) == 0),
                 ($urandom_range(0, 2) != 0), ($urandom_range(0, 3) != 0),
                 ($urandom_range(0, 1) == 1));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog R1..: run hung, actual running expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule